// File: doc/BRIEF.md
# Serial Command Register File for a Multiplexed LED Driver

This block takes 16-bit write words from a three-wire serial port (active-low select, serial clock, data in) and applies them to the configuration and display state of a multiplexed LED driver. Each word carries an 8-bit address in its upper byte and an 8-bit value in its lower byte. The block holds these registers:

- a per-digit decode mask
- a 4-bit brightness level
- a 3-bit scan limit
- the run, blink-rate and blink-enable flags
- a display-test flag
- two planes of eight digit bytes

Two configuration bits do not stay in any register. One clears the scan and blink timing. The other clears every digit byte. Each leaves behind a single system-clock pulse for the scanning logic downstream.

Bits are shifted in on the serial clock while select is low. The shift register keeps its contents across frames. When select rises, the last sixteen bits received are executed. The rising edge of select is brought into the system clock through a synchronizer. The word is then captured with a one-cycle valid strobe, which is safe because the shift register cannot move while select is high. No read path exists.

Top module: `led_cmd_regfile`

## Requirements
- R1: Data is sampled on rising serial clock edges while select is low, most significant bit first. Bits 15:8 of the word are the address and bits 7:0 are the value.
- R2: Serial clock and data activity while select is high leaves the shift register unchanged.
- R3: On the select rising edge, the last 16 bits shifted are executed. A longer frame keeps only its final 16 bits. A shorter frame is completed by the bits left from earlier frames.
- R4: Address 0x01 loads the whole decode mask. Address 0x02 loads the brightness from value bits 3:0. Address 0x03 loads the scan limit from bits 2:0. Address 0x07 loads the test flag from bit 0.
- R5: Address 0x04 stores three flags: bit 0 is run (1 = normal, 0 = shutdown), bit 2 is fast blink, and bit 3 is blink enable.
- R6: A 0x04 word with bit 4 set produces exactly one system-clock pulse on `timing_clr_o`, and the bit is not stored.
- R7: A 0x04 word with bit 5 set zeroes all digit bytes in both planes, and produces exactly one pulse on `digit_clr_o`.
- R8: Address 0x20+d writes digit d in plane 0 only. Address 0x40+d writes it in plane 1 only. Address 0x60+d writes the same byte to both planes. Digit d appears on bits [8d+7:8d] of each plane bus.
- R9: Addresses 0x00, 0x06 and every address not listed above change no output.
- R10: After reset the outputs are as follows: run 0, slow blink, blink off, decode mask 0x00, brightness 0, scan limit 4, test flag 0, and all digit bytes 0.
- R11: Each select rising edge executes the held word exactly once, including a frame with no clock pulses, which re-executes the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock |
| spi_cs_ni | input | 1 | Active-low select |
| spi_mosi_i | input | 1 | Serial data in |
| decode_mask_o | output | 8 | Per-digit decode enable |
| intensity_o | output | 4 | Brightness level |
| scan_limit_o | output | 3 | Highest scanned digit index |
| run_o | output | 1 | 1 = normal operation, 0 = shutdown |
| blink_fast_o | output | 1 | Fast blink rate selected |
| blink_en_o | output | 1 | Blink enabled |
| test_o | output | 1 | Display test active |
| plane0_o | output | 8*NUM_DIGITS | Digit bytes, plane 0 |
| plane1_o | output | 8*NUM_DIGITS | Digit bytes, plane 1 |
| timing_clr_o | output | 1 | One-cycle scan/blink timing clear |
| digit_clr_o | output | 1 | One-cycle pulse marking a digit clear |

## Verification
The bench uses the defaults: NUM_DIGITS = 8 and SYNC_STAGES = 2. With these values all three digit-address windows are reachable up to digit 7, and the digit-index decode is exercised for every plane-select code. The two-stage synchronizer keeps the time from select rising to an updated register short, so the bench can try frame lengths of 0, 8, 16 and 24 bits back to back. It also toggles the serial clock with select high between frames.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [7:0] ADR_DECODE = 8'h01;
  localparam logic [7:0] ADR_INTENS = 8'h02;
  localparam logic [7:0] ADR_SCAN   = 8'h03;
  localparam logic [7:0] ADR_CFG    = 8'h04;
  localparam logic [7:0] ADR_RSVD   = 8'h06;
  localparam logic [7:0] ADR_TEST   = 8'h07;

  localparam int CFG_RUN   = 0;
  localparam int CFG_FAST  = 2;
  localparam int CFG_BLINK = 3;
  localparam int CFG_TCLR  = 4;
  localparam int CFG_DCLR  = 5;

  typedef struct packed {
    logic run;
    logic blink_fast;
    logic blink_en;
  } cfg_t;

  // {plane1, plane0} write enables for a digit address, 0 otherwise
  function automatic logic [1:0] plane_sel(input logic [7:0] adr);
    if (!adr[7] && adr[4:3] == 2'b00) return adr[6:5];
    return 2'b00;
  endfunction
endpackage

// File: rtl/led_cmd_shift.sv
module led_cmd_shift #(
  parameter int WORD_W = 16
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (!cs_ni) sh_q <= {sh_q[WORD_W-2:0], mosi_i};
  end

  assign word_o = sh_q;

  a_r1_msb_first: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !cs_ni |=> (sh_q[WORD_W-1:1] == $past(sh_q[WORD_W-2:0])) && (sh_q[0] == $past(mosi_i)));

  a_r2_hold_when_deselected: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |=> sh_q == $past(sh_q));
endmodule

// File: rtl/led_cmd_cdc.sv
module led_cmd_cdc #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic [WORD_W-1:0]      word_q;
  logic                   valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cs_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // shift register is frozen while select is high, so a direct capture is safe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rise;
      if (rise) word_q <= word_i;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  a_r11_single_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/led_cmd_regs.sv
module led_cmd_regs
  import led_cmd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int PLANE_W   = NUM_DIGITS * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [7:0]         decode_mask_o,
  output logic [3:0]         intensity_o,
  output logic [2:0]         scan_limit_o,
  output cfg_t               cfg_o,
  output logic               test_o,
  output logic [PLANE_W-1:0] plane0_o,
  output logic [PLANE_W-1:0] plane1_o,
  output logic               timing_clr_o,
  output logic               digit_clr_o
);
  logic [7:0] adr, dat;
  logic       cfg_hit, clr_hit;
  logic [1:0] sel;

  assign adr     = word_i[15:8];
  assign dat     = word_i[7:0];
  assign cfg_hit = valid_i && (adr == ADR_CFG);
  assign clr_hit = cfg_hit && dat[CFG_DCLR];
  assign sel     = valid_i ? plane_sel(adr) : 2'b00;

  logic [7:0] decode_q;
  logic [3:0] intens_q;
  logic [2:0] scan_q;
  cfg_t       cfg_q;
  logic       test_q, tclr_q, dclr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decode_q <= '0;
      intens_q <= '0;
      scan_q   <= 3'd4;
      cfg_q    <= '0;
      test_q   <= 1'b0;
      tclr_q   <= 1'b0;
      dclr_q   <= 1'b0;
    end else begin
      tclr_q <= cfg_hit && dat[CFG_TCLR];
      dclr_q <= clr_hit;
      if (valid_i) begin
        unique case (adr)
          ADR_DECODE: decode_q <= dat;
          ADR_INTENS: intens_q <= dat[3:0];
          ADR_SCAN:   scan_q   <= dat[2:0];
          ADR_CFG:    cfg_q    <= '{run: dat[CFG_RUN], blink_fast: dat[CFG_FAST],
                                    blink_en: dat[CFG_BLINK]};
          ADR_TEST:   test_q   <= dat[0];
          default: ;
        endcase
      end
    end
  end

  logic [NUM_DIGITS-1:0][BYTE_W-1:0] p0_q, p1_q;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic hit;
    assign hit = (adr[2:0] == 3'(d));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p0_q[d] <= '0;
        p1_q[d] <= '0;
      end else if (clr_hit) begin
        p0_q[d] <= '0;
        p1_q[d] <= '0;
      end else if (hit) begin
        if (sel[0]) p0_q[d] <= dat;
        if (sel[1]) p1_q[d] <= dat;
      end
    end
  end

  assign decode_mask_o = decode_q;
  assign intensity_o   = intens_q;
  assign scan_limit_o  = scan_q;
  assign cfg_o         = cfg_q;
  assign test_o        = test_q;
  assign plane0_o      = p0_q;
  assign plane1_o      = p1_q;
  assign timing_clr_o  = tclr_q;
  assign digit_clr_o   = dclr_q;

  a_r6_timing_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tclr_q |=> !tclr_q);

  a_r7_clear_planes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclr_q |-> (p0_q == '0) && (p1_q == '0));

  a_r4_decode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (adr == ADR_DECODE) |=> decode_q == $past(dat));

  a_r9_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (adr == ADR_RSVD) |=> $stable(decode_q) && $stable(intens_q) &&
      $stable(scan_q) && $stable(cfg_q) && $stable(test_q) && $stable(p0_q) && $stable(p1_q));
endmodule

// File: rtl/led_cmd_regfile.sv
module led_cmd_regfile
  import led_cmd_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PLANE_W    = NUM_DIGITS * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               spi_sclk_i,
  input  logic               spi_cs_ni,
  input  logic               spi_mosi_i,
  output logic [7:0]         decode_mask_o,
  output logic [3:0]         intensity_o,
  output logic [2:0]         scan_limit_o,
  output logic               run_o,
  output logic               blink_fast_o,
  output logic               blink_en_o,
  output logic               test_o,
  output logic [PLANE_W-1:0] plane0_o,
  output logic [PLANE_W-1:0] plane1_o,
  output logic               timing_clr_o,
  output logic               digit_clr_o
);
  logic [WORD_W-1:0] sh_word, ex_word;
  logic              ex_valid;
  cfg_t              cfg;

  led_cmd_shift #(.WORD_W(WORD_W)) u_shift (
    .sclk_i (spi_sclk_i),
    .rst_ni (rst_ni),
    .cs_ni  (spi_cs_ni),
    .mosi_i (spi_mosi_i),
    .word_o (sh_word)
  );

  led_cmd_cdc #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (spi_cs_ni),
    .word_i  (sh_word),
    .word_o  (ex_word),
    .valid_o (ex_valid)
  );

  led_cmd_regs #(.NUM_DIGITS(NUM_DIGITS)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (ex_valid),
    .word_i        (ex_word),
    .decode_mask_o (decode_mask_o),
    .intensity_o   (intensity_o),
    .scan_limit_o  (scan_limit_o),
    .cfg_o         (cfg),
    .test_o        (test_o),
    .plane0_o      (plane0_o),
    .plane1_o      (plane1_o),
    .timing_clr_o  (timing_clr_o),
    .digit_clr_o   (digit_clr_o)
  );

  assign run_o        = cfg.run;
  assign blink_fast_o = cfg.blink_fast;
  assign blink_en_o   = cfg.blink_en;
endmodule

// File: tb/led_cmd_regfile_bench.sv
module led_cmd_regfile_bench;
  localparam int ND = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [7:0] decode;
  logic [3:0] intens;
  logic [2:0] scan;
  logic run, fast, blink, test, tclr, dclr;
  logic [ND*8-1:0] p0, p1;

  int checks = 0, fails = 0, tcnt = 0, dcnt = 0;

  always #10 clk = ~clk;

  led_cmd_regfile #(.NUM_DIGITS(ND), .SYNC_STAGES(2)) u_led_cmd_regfile (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .decode_mask_o(decode), .intensity_o(intens), .scan_limit_o(scan), .run_o(run),
    .blink_fast_o(fast), .blink_en_o(blink), .test_o(test), .plane0_o(p0), .plane1_o(p1),
    .timing_clr_o(tclr), .digit_clr_o(dclr)
  );

  always @(negedge clk) begin
    if (tclr) tcnt++;
    if (dclr) dcnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    cs_n = 1'b0;
    #40;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #40 cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    frame({16'h0, w}, 16);
  endtask

  function automatic logic [7:0] dig(input logic [ND*8-1:0] p, input int d);
    return p[8*d +: 8];
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R10 run", run, 0);
    chk("R10 fast", fast, 0);
    chk("R10 blink", blink, 0);
    chk("R10 decode", decode, 0);
    chk("R10 intensity", intens, 0);
    chk("R10 scan", scan, 4);
    chk("R10 test", test, 0);
    chk("R10 planes", {p0, p1}, 0);
  endtask

  task automatic t_regs;
    wr(16'h01A5); chk("R1 R4 decode", decode, 8'hA5);
    wr(16'h02F7); chk("R4 intensity", intens, 4'h7);
    wr(16'h03FD); chk("R4 scan", scan, 3'd5);
    wr(16'h0703); chk("R4 test on", test, 1);
    wr(16'h0702); chk("R4 test off", test, 0);
  endtask

  task automatic t_cfg;
    wr(16'h040D);
    chk("R5 run", run, 1); chk("R5 fast", fast, 1); chk("R5 blink", blink, 1);
    chk("R5 no tclr", tcnt, 0); chk("R5 no dclr", dcnt, 0);
    wr(16'h0400);
    chk("R5 cleared", {run, fast, blink}, 0);
    wr(16'h0415);
    chk("R6 pulse count", tcnt, 1);
    chk("R6 flags", {run, fast, blink}, 3'b110);
  endtask

  task automatic t_digits;
    wr(16'h2311);
    chk("R8 p0 only", dig(p0, 3), 8'h11); chk("R8 p1 untouched", dig(p1, 3), 0);
    wr(16'h4322);
    chk("R8 p1 only", dig(p1, 3), 8'h22); chk("R8 p0 kept", dig(p0, 3), 8'h11);
    wr(16'h6733);
    chk("R8 both p0", dig(p0, 7), 8'h33); chk("R8 both p1", dig(p1, 7), 8'h33);
    wr(16'h2044);
    chk("R8 digit0", dig(p0, 0), 8'h44);
  endtask

  task automatic t_nop;
    logic [ND*16-1:0] pl;
    pl = {p0, p1};
    wr(16'h00FF); wr(16'h06FF); wr(16'h10FF); wr(16'h80FF); wr(16'h05FF);
    chk("R9 decode", decode, 8'hA5);
    chk("R9 intensity", intens, 4'h7);
    chk("R9 scan", scan, 3'd5);
    chk("R9 flags", {run, fast, blink, test}, 4'b1100);
    chk("R9 planes", {p0, p1}, pl);
    chk("R9 pulses", tcnt + dcnt, 1);
  endtask

  task automatic t_clear;
    wr(16'h0420);
    chk("R7 p0 zero", p0, 0); chk("R7 p1 zero", p1, 0);
    chk("R7 pulse count", dcnt, 1); chk("R7 no tclr", tcnt, 1);
  endtask

  task automatic t_frames;
    wr(16'h5507);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1;
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    frame(32'h01, 8);
    chk("R2 R3 short frame", test, 1);
    frame(32'hFF0203, 24);
    chk("R3 long frame", intens, 4'h3);
    wr(16'h0411);
    chk("R11 first", tcnt, 2);
    frame(32'h0, 0);
    chk("R11 empty frame re-exec", tcnt, 3);
    chk("R11 run", run, 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regs;
    t_cfg;
    t_digits;
    t_nop;
    t_clear;
    t_frames;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule